// File: doc/BRIEF.md
# Saturating Velocity Command Writer

This block is a bus master that programs a motor control register block over an AXI4-Lite write channel. A velocity request carries four signed commands: lateral x, lateral y, vertical z and yaw rate. Each command is a 24-bit signed value with 16 fraction bits. Every command is turned into a 16-bit word with 12 fraction bits, saturated to the signed 16-bit range, and written to its own register. A final write then selects manual control.

Two control pulses start fixed register sequences. The enable pulse switches the pipeline on, sets the motor-enable flag and loads the trigger period. The disable pulse switches the pipeline and the motors off. Only one sequence runs at a time, and busy stays high until its last write response arrives.

The velocity request uses a valid/ready handshake, and back-pressure works as follows. `cmd_ready` is high only when no sequence is running and neither control pulse is present in the same cycle. A request is taken on a clock edge where `cmd_valid` and `cmd_ready` are both high. The four command inputs are captured at that edge, so the requester may change them afterwards. Control pulses that arrive while busy is high are dropped. The write channel follows the AXI4-Lite rules: the address and data stay stable until their own handshake, and only one write is in flight at a time.

Top module: `velcmd_writer`

## Requirements
- R1: Each command c, a 24-bit signed value with 16 fraction bits, is reduced to floor(c / 16), which has 12 fraction bits. A result above 32767 becomes 32767, and a result below -32768 becomes -32768.
- R2: Every command word is written as its 16 low bits in wdata[15:0], with wdata[31:16] zero. Every write has wstrb = 4'b1111.
- R3: A velocity request writes the converted commands in the order x, y, z, yaw to offsets 0x0C, 0x10, 0x14 and 0x18. It then writes the value 1 to offset 0x1C.
- R4: An enable pulse writes 1 to offset 0x00. It then writes the motor-enable input (1 or 0) to offset 0x04. It then writes 100000 to offset 0x08.
- R5: A disable pulse writes 0 to offset 0x00 and then 0 to offset 0x04.
- R6: While busy is high, `cmd_ready` is low. Requests and control pulses that arrive in this time are ignored and cause no writes.
- R7: busy rises in the cycle after a request is accepted and stays high until the clock edge where the last write response is taken. When busy is low, no write channel valid or ready signal is asserted.
- R8: A write response other than OKAY (bresp != 2'b00) ends the current sequence at that write and sets `err`. `err` stays set until the next request or pulse is accepted, which clears it.
- R9: If several requests arrive in the same idle cycle, disable wins over enable, and enable wins over a velocity request. `cmd_ready` is low in that cycle.
- R10: awvalid and wvalid stay asserted, with a stable address or data, until their own handshake. The address and data handshakes may complete in either order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Velocity request valid |
| cmd_ready | output | 1 | Velocity request ready |
| cmd_vx | input | 24 | x command, signed, 16 fraction bits |
| cmd_vy | input | 24 | y command, signed, 16 fraction bits |
| cmd_vz | input | 24 | z command, signed, 16 fraction bits |
| cmd_yaw | input | 24 | Yaw-rate command, signed, 16 fraction bits |
| en_pulse | input | 1 | Start the enable sequence |
| en_motors | input | 1 | Motor-enable value written by the enable sequence |
| dis_pulse | input | 1 | Start the disable sequence |
| busy | output | 1 | A sequence is in progress |
| err | output | 1 | Sticky error response flag |
| awaddr | output | 8 | Write address |
| awvalid | output | 1 | Write address valid |
| awready | input | 1 | Write address ready |
| wdata | output | 32 | Write data |
| wstrb | output | 4 | Write byte strobes |
| wvalid | output | 1 | Write data valid |
| wready | input | 1 | Write data ready |
| bresp | input | 2 | Write response code |
| bvalid | input | 1 | Write response valid |
| bready | output | 1 | Write response ready |

## Verification
The conversion is swept over several groups of values:
- 16 values each across the positive and negative saturation thresholds, which separate the clamp from plain truncation.
- A band around zero, which exposes rounding toward zero where the required rounding is toward negative infinity.
- A coarse walk across the whole 24-bit input range.

Each request places four different values on its four lanes, so swapped or mis-ordered registers show up.

A slave model stalls the address and data handshakes in patterns that differ from each other. It can inject an error response on a chosen write, which exercises the early stop and the sticky flag. Pulses applied while busy, and simultaneous pulses while idle, test the dropping and priority rules.

// File: rtl/vcw_pkg.sv
package vcw_pkg;
  typedef enum logic [1:0] {OP_CMD, OP_EN, OP_DIS} op_t;

  localparam logic [7:0] OFS_RUN    = 8'h00;
  localparam logic [7:0] OFS_MOTOR  = 8'h04;
  localparam logic [7:0] OFS_PERIOD = 8'h08;
  localparam logic [7:0] OFS_VX     = 8'h0C;
  localparam logic [7:0] OFS_MODE   = 8'h1C;
  localparam logic [1:0] RESP_OKAY  = 2'b00;
endpackage

// File: rtl/vcw_sat.sv
module vcw_sat #(
  parameter int LANES    = 4,
  parameter int IN_W     = 24,
  parameter int IN_FRAC  = 16,
  parameter int OUT_W    = 16,
  parameter int OUT_FRAC = 12
) (
  input  logic [LANES-1:0][IN_W-1:0]  raw,
  output logic [LANES-1:0][OUT_W-1:0] conv
);
  localparam int SH = IN_FRAC - OUT_FRAC;
  localparam int MW = IN_W - SH;
  localparam logic signed [MW-1:0] HI = MW'((1 << (OUT_W - 1)) - 1);
  localparam logic signed [MW-1:0] LO = -HI - MW'(1);

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic signed [MW-1:0] trunc;
    // dropping low fraction bits of two's complement floors toward -inf
    assign trunc = raw[g][IN_W-1:SH];
    always_comb begin
      if (trunc > HI)      conv[g] = HI[OUT_W-1:0];
      else if (trunc < LO) conv[g] = LO[OUT_W-1:0];
      else                 conv[g] = trunc[OUT_W-1:0];
    end
  end
endmodule

// File: rtl/vcw_axi_wr.sv
module vcw_axi_wr #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              go,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] data,
  output logic              idle,
  output logic              done,
  output logic [1:0]        resp,
  output logic [ADDR_W-1:0] awaddr,
  output logic              awvalid,
  input  logic              awready,
  output logic [DATA_W-1:0] wdata,
  output logic [DATA_W/8-1:0] wstrb,
  output logic              wvalid,
  input  logic              wready,
  input  logic [1:0]        bresp,
  input  logic              bvalid,
  output logic              bready
);
  typedef enum logic [1:0] {E_IDLE, E_ADDR, E_RESP} est_t;
  est_t st;
  logic aw_done, w_done, aw_nxt, w_nxt;

  assign awvalid = (st == E_ADDR) && !aw_done;
  assign wvalid  = (st == E_ADDR) && !w_done;
  assign wstrb   = '1;
  assign bready  = (st == E_RESP);
  assign idle    = (st == E_IDLE);
  assign done    = bvalid && bready;
  assign resp    = bresp;

  always_comb begin
    aw_nxt = aw_done || (awvalid && awready);
    w_nxt  = w_done  || (wvalid && wready);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st      <= E_IDLE;
      aw_done <= 1'b0;
      w_done  <= 1'b0;
      awaddr  <= '0;
      wdata   <= '0;
    end else begin
      case (st)
        E_IDLE: if (go) begin
          awaddr  <= addr;
          wdata   <= data;
          aw_done <= 1'b0;
          w_done  <= 1'b0;
          st      <= E_ADDR;
        end
        E_ADDR: begin
          aw_done <= aw_nxt;
          w_done  <= w_nxt;
          if (aw_nxt && w_nxt) st <= E_RESP;
        end
        default: if (bvalid) st <= E_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/vcw_seq.sv
module vcw_seq
  import vcw_pkg::*;
#(
  parameter int LANES  = 4,
  parameter int OUT_W  = 16,
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32,
  parameter int PERIOD = 100000
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        cmd_valid,
  input  logic [LANES-1:0][OUT_W-1:0] conv,
  input  logic                        en_pulse,
  input  logic                        en_motors,
  input  logic                        dis_pulse,
  output logic                        cmd_ready,
  output logic                        busy,
  output logic                        err,
  input  logic                        wr_idle,
  input  logic                        wr_done,
  input  logic [1:0]                  wr_resp,
  output logic                        go,
  output logic [ADDR_W-1:0]           addr,
  output logic [DATA_W-1:0]           data
);
  localparam int SW = $clog2(LANES + 2);

  op_t                        op;
  logic [SW-1:0]              step, last;
  logic                       active, motors_q;
  logic [LANES-1:0][OUT_W-1:0] words_q;
  logic take_dis, take_en, take_cmd;

  assign cmd_ready = !active && !dis_pulse && !en_pulse;
  assign take_dis  = !active && dis_pulse;
  assign take_en   = !active && !dis_pulse && en_pulse;
  assign take_cmd  = cmd_ready && cmd_valid;
  assign busy      = active;
  assign go        = active && wr_idle;

  always_comb begin
    addr = '0;
    data = '0;
    last = '0;
    case (op)
      OP_CMD: begin
        last = SW'(LANES);
        if (int'(step) < LANES) begin
          addr = ADDR_W'(OFS_VX) + ADDR_W'(4 * int'(step));
          data = DATA_W'(words_q[step]);
        end else begin
          addr = ADDR_W'(OFS_MODE);
          data = DATA_W'(1);
        end
      end
      OP_EN: begin
        last = SW'(2);
        case (step)
          SW'(0):  begin addr = ADDR_W'(OFS_RUN);   data = DATA_W'(1); end
          SW'(1):  begin addr = ADDR_W'(OFS_MOTOR); data = DATA_W'(motors_q); end
          default: begin addr = ADDR_W'(OFS_PERIOD); data = DATA_W'(PERIOD); end
        endcase
      end
      default: begin
        last = SW'(1);
        addr = (step == '0) ? ADDR_W'(OFS_RUN) : ADDR_W'(OFS_MOTOR);
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active   <= 1'b0;
      err      <= 1'b0;
      step     <= '0;
      op       <= OP_CMD;
      motors_q <= 1'b0;
      words_q  <= '0;
    end else if (take_dis || take_en || take_cmd) begin
      active <= 1'b1;
      err    <= 1'b0;
      step   <= '0;
      op     <= take_dis ? OP_DIS : (take_en ? OP_EN : OP_CMD);
      if (take_en)  motors_q <= en_motors;
      if (take_cmd) words_q  <= conv;
    end else if (active && wr_done) begin
      if (wr_resp != RESP_OKAY) begin
        active <= 1'b0;
        err    <= 1'b1;
      end else if (step == last) begin
        active <= 1'b0;
      end else begin
        step <= step + SW'(1);
      end
    end
  end
endmodule

// File: rtl/velcmd_writer.sv
module velcmd_writer #(
  parameter int IN_W     = 24,
  parameter int IN_FRAC  = 16,
  parameter int OUT_W    = 16,
  parameter int OUT_FRAC = 12,
  parameter int ADDR_W   = 8,
  parameter int DATA_W   = 32,
  parameter int PERIOD   = 100000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  output logic              cmd_ready,
  input  logic [IN_W-1:0]   cmd_vx,
  input  logic [IN_W-1:0]   cmd_vy,
  input  logic [IN_W-1:0]   cmd_vz,
  input  logic [IN_W-1:0]   cmd_yaw,
  input  logic              en_pulse,
  input  logic              en_motors,
  input  logic              dis_pulse,
  output logic              busy,
  output logic              err,
  output logic [ADDR_W-1:0] awaddr,
  output logic              awvalid,
  input  logic              awready,
  output logic [DATA_W-1:0] wdata,
  output logic [DATA_W/8-1:0] wstrb,
  output logic              wvalid,
  input  logic              wready,
  input  logic [1:0]        bresp,
  input  logic              bvalid,
  output logic              bready
);
  localparam int LANES = 4;

  logic [LANES-1:0][IN_W-1:0]  raw;
  logic [LANES-1:0][OUT_W-1:0] conv;
  logic              go, wr_idle, wr_done;
  logic [1:0]        wr_resp;
  logic [ADDR_W-1:0] nx_addr;
  logic [DATA_W-1:0] nx_data;

  assign raw = {cmd_yaw, cmd_vz, cmd_vy, cmd_vx};

  vcw_sat #(.LANES(LANES), .IN_W(IN_W), .IN_FRAC(IN_FRAC),
            .OUT_W(OUT_W), .OUT_FRAC(OUT_FRAC)) u_sat (
    .raw(raw), .conv(conv));

  vcw_seq #(.LANES(LANES), .OUT_W(OUT_W), .ADDR_W(ADDR_W),
            .DATA_W(DATA_W), .PERIOD(PERIOD)) u_seq (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .conv(conv),
    .en_pulse(en_pulse), .en_motors(en_motors), .dis_pulse(dis_pulse),
    .cmd_ready(cmd_ready), .busy(busy), .err(err),
    .wr_idle(wr_idle), .wr_done(wr_done), .wr_resp(wr_resp),
    .go(go), .addr(nx_addr), .data(nx_data));

  vcw_axi_wr #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_wr (
    .clk(clk), .rst_n(rst_n), .go(go), .addr(nx_addr), .data(nx_data),
    .idle(wr_idle), .done(wr_done), .resp(wr_resp),
    .awaddr(awaddr), .awvalid(awvalid), .awready(awready),
    .wdata(wdata), .wstrb(wstrb), .wvalid(wvalid), .wready(wready),
    .bresp(bresp), .bvalid(bvalid), .bready(bready));
endmodule

// File: rtl/vcw_checker.sv
module vcw_checker #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              busy,
  input logic              err,
  input logic              cmd_ready,
  input logic [ADDR_W-1:0] awaddr,
  input logic              awvalid,
  input logic              awready,
  input logic [DATA_W-1:0] wdata,
  input logic              wvalid,
  input logic              wready,
  input logic [1:0]        bresp,
  input logic              bvalid,
  input logic              bready
);
  a_r10_aw_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (awvalid && !awready) |=> (awvalid && $stable(awaddr)));

  a_r10_w_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (wvalid && !wready) |=> (wvalid && $stable(wdata)));

  a_r6_not_ready_busy: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !cmd_ready);

  a_r7_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!awvalid && !wvalid && !bready));

  a_r7_one_in_flight: assert property (@(posedge clk) disable iff (!rst_n)
    bready |-> (!awvalid && !wvalid));

  a_r8_err_stops: assert property (@(posedge clk) disable iff (!rst_n)
    (bvalid && bready && bresp != 2'b00) |=> (!busy && err));
endmodule

bind velcmd_writer vcw_checker #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .err(err), .cmd_ready(cmd_ready),
  .awaddr(awaddr), .awvalid(awvalid), .awready(awready),
  .wdata(wdata), .wvalid(wvalid), .wready(wready),
  .bresp(bresp), .bvalid(bvalid), .bready(bready));

// File: tb/velcmd_writer_test.sv
`timescale 1ns/1ps
module velcmd_writer_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cmd_valid = 1'b0, en_pulse = 1'b0, en_motors = 1'b0, dis_pulse = 1'b0;
  logic [23:0] cmd_vx = '0, cmd_vy = '0, cmd_vz = '0, cmd_yaw = '0;
  logic cmd_ready, busy, err, awvalid, wvalid, bready;
  logic [7:0] awaddr;
  logic [31:0] wdata;
  logic [3:0] wstrb;
  logic awready = 1'b0, wready = 1'b0, bvalid = 1'b0;
  logic [1:0] bresp = 2'b00;

  always #2.5 clk = ~clk;

  velcmd_writer uut (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_vx(cmd_vx), .cmd_vy(cmd_vy), .cmd_vz(cmd_vz), .cmd_yaw(cmd_yaw),
    .en_pulse(en_pulse), .en_motors(en_motors), .dis_pulse(dis_pulse),
    .busy(busy), .err(err), .awaddr(awaddr), .awvalid(awvalid),
    .awready(awready), .wdata(wdata), .wstrb(wstrb), .wvalid(wvalid),
    .wready(wready), .bresp(bresp), .bvalid(bvalid), .bready(bready));

  int n_vec = 0, n_bad = 0;
  int a_log[16], d_log[16], s_log[16];
  int aw_i = 0, w_i = 0, b_i = 0, bad_idx = -1, cnt = 0;
  bit aw_got = 0, w_got = 0, finished = 0;

  // slave model: decisions at negedge, handshakes complete at next posedge
  initial begin
    forever begin
      @(negedge clk);
      cnt++;
      if (bvalid) bvalid = 1'b0;
      if (awready) begin awready = 1'b0; aw_got = 1; end
      else if (awvalid && !aw_got && (cnt % 3) != 1) begin
        awready = 1'b1;
        if (aw_i < 16) a_log[aw_i] = int'(awaddr);
        aw_i++;
      end
      if (wready) begin wready = 1'b0; w_got = 1; end
      else if (wvalid && !w_got && (cnt % 2) == 0) begin
        wready = 1'b1;
        if (w_i < 16) begin d_log[w_i] = int'(wdata); s_log[w_i] = int'(wstrb); end
        w_i++;
      end
      if (aw_got && w_got) begin
        bvalid = 1'b1;
        bresp  = (b_i == bad_idx) ? 2'b10 : 2'b00;
        b_i++;
        aw_got = 0;
        w_got  = 0;
      end
    end
  end

  task automatic check(input string tag, input int act, input int exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d (0x%0h) expected=%0d (0x%0h)", tag, act, act, exp, exp);
    end
  endtask

  function automatic int conv_exp(input int v);
    int t;
    t = v >>> 4;
    if (t > 32767) t = 32767;
    if (t < -32768) t = -32768;
    return t & 32'hFFFF;
  endfunction

  function automatic int val_of(input int k);
    if (k < 16) return 524280 + k;
    if (k < 32) return -524296 + (k - 16);
    if (k < 48) return -8 + (k - 32);
    return -8388608 + (k - 48) * 87381 + (k * 7) % 16;
  endfunction

  task automatic clear_log();
    aw_i = 0; w_i = 0; b_i = 0;
  endtask

  // wait for an accepted sequence to finish
  task automatic finish_seq(input string tag);
    @(negedge clk);
    check({tag, " R7 busy after accept"}, int'(busy), 1);
    while (busy) @(negedge clk);
  endtask

  task automatic run_cmd(input int vx, input int vy, input int vz, input int vy2);
    int vals[4];
    vals = '{vx, vy, vz, vy2};
    clear_log();
    cmd_vx = 24'(vx); cmd_vy = 24'(vy); cmd_vz = 24'(vz); cmd_yaw = 24'(vy2);
    cmd_valid = 1'b1;
    @(negedge clk);
    cmd_valid = 1'b0;
    cmd_vx = '0; cmd_vy = '0; cmd_vz = '0; cmd_yaw = '0;
    check("R7 busy after accept", int'(busy), 1);
    while (busy) @(negedge clk);
    check("R3 write count", aw_i, 5);
    for (int i = 0; i < 4; i++) begin
      check("R3 command address", a_log[i], 12 + 4 * i);
      check("R1 R2 converted data", d_log[i], conv_exp(vals[i]));
      check("R2 strobes", s_log[i], 15);
    end
    check("R3 mode address", a_log[4], 28);
    check("R3 mode data", d_log[4], 1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_bad++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    check("reset busy", int'(busy), 0);
    check("reset awvalid", int'(awvalid), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check("reset cmd_ready", int'(cmd_ready), 1);
    check("reset err", int'(err), 0);
    check("R7 idle wvalid", int'(wvalid), 0);

    // R1 R2 R3 sweep with distinct lane values
    for (int k = 0; k < 240; k++)
      run_cmd(val_of(k), val_of((k + 61) % 240), val_of((k + 127) % 240),
              val_of((k + 199) % 240));

    // R4 enable sequence, both motor flag values
    for (int m = 0; m < 2; m++) begin
      clear_log();
      en_motors = 1'(m);
      en_pulse = 1'b1;
      @(negedge clk);
      en_pulse = 1'b0;
      en_motors = 1'b0;
      while (busy) @(negedge clk);
      check("R4 write count", aw_i, 3);
      check("R4 run addr", a_log[0], 0);
      check("R4 run data", d_log[0], 1);
      check("R4 motor addr", a_log[1], 4);
      check("R4 motor data", d_log[1], m);
      check("R4 period addr", a_log[2], 8);
      check("R4 period data", d_log[2], 100000);
    end

    // R5 disable sequence
    clear_log();
    dis_pulse = 1'b1;
    @(negedge clk);
    dis_pulse = 1'b0;
    while (busy) @(negedge clk);
    check("R5 write count", aw_i, 2);
    check("R5 run addr", a_log[0], 0);
    check("R5 run data", d_log[0], 0);
    check("R5 motor addr", a_log[1], 4);
    check("R5 motor data", d_log[1], 0);

    // R6 pulses and requests while busy are dropped
    clear_log();
    cmd_vx = 24'(100); cmd_valid = 1'b1;
    @(negedge clk);
    check("R6 ready low while busy", int'(cmd_ready), 0);
    dis_pulse = 1'b1; en_pulse = 1'b1;
    @(negedge clk);
    dis_pulse = 1'b0; en_pulse = 1'b0;
    @(negedge clk);
    cmd_valid = 1'b0; cmd_vx = '0;
    while (busy) @(negedge clk);
    repeat (10) @(negedge clk);
    check("R6 no extra writes", aw_i, 5);
    check("R6 still idle", int'(busy), 0);

    // R9 priority: disable over enable over command
    clear_log();
    dis_pulse = 1'b1; en_pulse = 1'b1; cmd_valid = 1'b1;
    #1;
    check("R9 ready low on pulse", int'(cmd_ready), 0);
    @(negedge clk);
    dis_pulse = 1'b0; en_pulse = 1'b0; cmd_valid = 1'b0;
    while (busy) @(negedge clk);
    check("R9 disable wins count", aw_i, 2);
    check("R9 disable wins data", d_log[0], 0);
    clear_log();
    en_pulse = 1'b1; cmd_valid = 1'b1;
    @(negedge clk);
    en_pulse = 1'b0; cmd_valid = 1'b0;
    while (busy) @(negedge clk);
    check("R9 enable wins count", aw_i, 3);
    check("R9 enable wins addr", a_log[2], 8);

    // R8 error response stops sequence, sticky until next accept
    clear_log();
    bad_idx = 2;
    cmd_valid = 1'b1;
    @(negedge clk);
    cmd_valid = 1'b0;
    while (busy) @(negedge clk);
    bad_idx = -1;
    repeat (5) @(negedge clk);
    check("R8 stopped after bad write", aw_i, 3);
    check("R8 err set", int'(err), 1);
    check("R8 err sticky", int'(err), 1);
    clear_log();
    dis_pulse = 1'b1;
    @(negedge clk);
    dis_pulse = 1'b0;
    check("R8 err cleared on accept", int'(err), 0);
    while (busy) @(negedge clk);
    check("R8 later sequence complete", aw_i, 2);
    check("R8 err stays clear", int'(err), 0);

    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule